// File: doc/BRIEF.md
# Vertical Retrace Interrupt Unit

This unit tells software that the display scan has entered vertical blanking. Two raw indicators come from the raster timing logic, which runs in another clock domain. One is high during the blanking interval. The other is high while the scan sits at the first pixel of a frame. Each indicator crosses into the register clock through its own synchroniser. Entry into blanking is detected on the synchronised signal, and it sets a status flag that software can poll. It also sets a pending request, which drives the interrupt line when the enable bit is 1.

Clearing is split in two. A software write with the acknowledge bit set drops the pending request at once. The status flag stays at 1 until the synchronised top-of-frame indicator is seen. That indicator also drops any request that is still pending.

Top module: `vblank_irq_unit`

## Requirements
- R1: While `rst_n` is low, `stat_flag` and `irq_out` are 0 and all internal state is cleared.
- R2: A 0-to-1 change of `vblank_raw` sets `stat_flag` to 1 and makes a request pending.
- R3: `vblank_raw` and `frame_top_raw` each take effect at the (SYNC_STAGES+1)-th rising clock edge after the first edge that samples the new level. With the default SYNC_STAGES=2, that is the third edge.
- R4: Setting is edge-triggered. While `vblank_raw` stays high, a cleared request is not raised again.
- R5: `irq_out` equals the pending request ANDed with `irq_en`. With `irq_en` at 0 the request stays pending and can still be polled through `stat_flag`. Setting `irq_en` to 1 later shows the request at once.
- R6: `stat_flag` falls to 0 only when `frame_top_raw` is seen high, and this holds even after the request has been acknowledged. The same event also drops any request still pending.
- R7: A cycle with `clr_we`=1 and bit CLR_BIT of `clr_wdata` at 1 clears the pending request at that edge. A write whose bit CLR_BIT is 0 has no effect.
- R8: When a detected blank entry falls on the same edge as a clearing write or a top-of-frame event, the set wins and both the flag and the request are 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vblank_raw | input | 1 | Unsynchronised vertical-blank level |
| frame_top_raw | input | 1 | Unsynchronised level, high at the first pixel of a frame |
| clr_we | input | 1 | Write strobe to the status register |
| clr_wdata | input | DATA_W | Write data; bit CLR_BIT acknowledges the request |
| irq_en | input | 1 | Interrupt enable (mask) bit |
| stat_flag | output | 1 | Pollable status flag |
| irq_out | output | 1 | Interrupt request line |

## Verification
The bench builds the unit with SYNC_STAGES=2, DATA_W=8 and CLR_BIT=3. With SYNC_STAGES=2 the latency can be counted exactly, edge by edge. Placing the acknowledge bit away from bit 0 shows that only that bit position clears the request. A short synchroniser also makes it easy to line a clearing write or a top-of-frame pulse up with the very edge on which a blank entry is detected. Outside those alignments, random frame-like stimulus is compared with a cycle model built from the requirements.

// File: rtl/vri_pkg.sv
package vri_pkg;

    typedef struct packed {
        logic status;     // pollable flag
        logic pending;    // request waiting for acknowledge
        logic blank_prev; // last synchronised blank level
    } vri_state_t;

    localparam vri_state_t VRI_RESET = '{status: 1'b0, pending: 1'b0, blank_prev: 1'b0};

endpackage

// File: rtl/vri_sync.sv
module vri_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d;
    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[LAST];

endmodule

// File: rtl/vri_core.sv
module vri_core
    import vri_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blank_s,
    input  logic top_s,
    input  logic ack,
    input  logic irq_en,
    output logic stat_flag,
    output logic irq_out
);
    vri_state_t st_d;
    vri_state_t st_q;
    logic       rise;

    always_comb begin
        st_d            = st_q;
        rise            = blank_s & ~st_q.blank_prev;
        st_d.blank_prev = blank_s;
        if (rise) begin
            st_d.status  = 1'b1;
            st_d.pending = 1'b1;
        end else begin
            if (top_s) begin
                st_d.status  = 1'b0;
                st_d.pending = 1'b0;
            end
            if (ack) st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= VRI_RESET;
        else        st_q <= st_d;
    end

    assign stat_flag = st_q.status;
    assign irq_out   = st_q.pending & irq_en;

    a_r2_set_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_s && !st_q.blank_prev) |=> (stat_flag && st_q.pending));

    a_r5_request_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> stat_flag);

    a_r6_flag_holds_without_top: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flag && !top_s) |=> stat_flag);

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(blank_s && !st_q.blank_prev)) |=> !st_q.pending);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_s && !st_q.blank_prev && (ack || top_s)) |=> (stat_flag && st_q.pending));

    a_r4_no_reraise_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pending && st_q.blank_prev && blank_s) |=> !st_q.pending);

endmodule

// File: rtl/vblank_irq_unit.sv
module vblank_irq_unit #(
    parameter int DATA_W      = 8,
    parameter int CLR_BIT     = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vblank_raw,
    input  logic              frame_top_raw,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_wdata,
    input  logic              irq_en,
    output logic              stat_flag,
    output logic              irq_out
);
    logic blank_s;
    logic top_s;
    logic ack;

    assign ack = clr_we & clr_wdata[CLR_BIT];

    vri_sync #(.STAGES(SYNC_STAGES)) u_sync_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (vblank_raw),
        .sync_out (blank_s)
    );

    vri_sync #(.STAGES(SYNC_STAGES)) u_sync_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (frame_top_raw),
        .sync_out (top_s)
    );

    vri_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .blank_s   (blank_s),
        .top_s     (top_s),
        .ack       (ack),
        .irq_en    (irq_en),
        .stat_flag (stat_flag),
        .irq_out   (irq_out)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!stat_flag && !irq_out));

endmodule

// File: tb/vblank_irq_unit_test.sv
module vblank_irq_unit_test;
    localparam int DW = 8;
    localparam int CB = 3;
    localparam int SS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vb = 1'b0;
    logic          tp = 1'b0;
    logic          we = 1'b0;
    logic [DW-1:0] wd = '0;
    logic          en = 1'b0;
    logic          stat_flag;
    logic          irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // requirement-level model
    logic [SS-1:0] m_bs, m_ts;
    logic          m_bp, m_st, m_pd;

    always #5 clk = ~clk;

    vblank_irq_unit #(.DATA_W(DW), .CLR_BIT(CB), .SYNC_STAGES(SS)) uut (
        .clk(clk), .rst_n(rst_n), .vblank_raw(vb), .frame_top_raw(tp),
        .clr_we(we), .clr_wdata(wd), .irq_en(en),
        .stat_flag(stat_flag), .irq_out(irq_out)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_irq();
        return m_pd & en;
    endfunction

    task automatic model_reset();
        m_bs = '0; m_ts = '0; m_bp = 0; m_st = 0; m_pd = 0;
    endtask

    task automatic model_edge();
        logic rise, top, ack;
        rise = m_bs[SS-1] & ~m_bp;
        top  = m_ts[SS-1];
        ack  = we & wd[CB];
        m_st = rise | (m_st & ~top);
        m_pd = rise | (m_pd & ~top & ~ack);
        m_bp = m_bs[SS-1];
        m_bs = {m_bs[SS-2:0], vb};
        m_ts = {m_ts[SS-2:0], tp};
    endtask

    // one clock: model follows inputs present at the edge, then compare
    task automatic cyc();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk("model R2/R3/R6 status", stat_flag, m_st);
        chk("model R5/R7/R8 irq", irq_out, exp_irq());
    endtask

    task automatic cycn(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset status", stat_flag, 1'b0);
        chk("R1 reset irq", irq_out, 1'b0);
        rst_n = 1'b1;
        en = 1'b1;

        // R2/R3: entry sets after exactly SS+1 edges
        vb = 1'b1;
        cycn(2);
        chk("R3 not yet status", stat_flag, 1'b0);
        cyc();
        chk("R2 R3 status set", stat_flag, 1'b1);
        chk("R2 irq set", irq_out, 1'b1);

        // R7: wrong bit ignored, right bit clears
        we = 1'b1; wd = 8'hF7;
        cyc();
        chk("R7 wrong bit ignored", irq_out, 1'b1);
        wd = 8'h08;
        cyc();
        we = 1'b0; wd = '0;
        chk("R7 ack clears irq", irq_out, 1'b0);
        chk("R6 flag survives ack", stat_flag, 1'b1);

        // R4: long blank, no new request
        cycn(10);
        chk("R4 no reraise", irq_out, 1'b0);
        vb = 1'b0;
        cycn(5);
        chk("R6 flag holds after blank", stat_flag, 1'b1);

        // R6: top-of-frame clears after SS+1 edges
        tp = 1'b1;
        cyc();
        tp = 1'b0;
        cyc();
        chk("R6 R3 not yet cleared", stat_flag, 1'b1);
        cyc();
        chk("R6 flag cleared", stat_flag, 1'b0);

        // R5: masked request stays pending
        en = 1'b0;
        vb = 1'b1;
        cycn(3);
        chk("R5 polled flag", stat_flag, 1'b1);
        chk("R5 masked irq", irq_out, 1'b0);
        cycn(4);
        en = 1'b1;
        #1;
        chk("R5 unmask shows pending", irq_out, 1'b1);
        // R6: top also drops pending request
        vb = 1'b0;
        tp = 1'b1;
        cyc();
        tp = 1'b0;
        cycn(3);
        chk("R6 top drops request", irq_out, 1'b0);
        chk("R6 top clears flag", stat_flag, 1'b0);

        // R8: ack on the detection edge
        vb = 1'b1;
        cycn(2);
        we = 1'b1; wd = 8'h08;
        cyc();
        we = 1'b0; wd = '0;
        chk("R8 set beats ack irq", irq_out, 1'b1);
        chk("R8 set beats ack flag", stat_flag, 1'b1);
        vb = 1'b0;
        cycn(4);
        // R8: top on the detection edge
        vb = 1'b1; tp = 1'b1;
        cyc();
        tp = 1'b0;
        cycn(2);
        chk("R8 set beats top flag", stat_flag, 1'b1);
        chk("R8 set beats top irq", irq_out, 1'b1);
        vb = 1'b0;
        cycn(4);

        // random frames
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 15) == 0) vb = ~vb;
            tp = ($urandom_range(0, 29) == 0);
            we = ($urandom_range(0, 9) == 0);
            wd = DW'($urandom);
            if ($urandom_range(0, 31) == 0) en = ~en;
            cyc();
        end

        // R1: reset mid-run
        vb = 1'b1; cycn(4);
        rst_n = 1'b0;
        model_reset();
        #1;
        chk("R1 async reset status", stat_flag, 1'b0);
        chk("R1 async reset irq", irq_out, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule